// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters over the one open-drain data wire between a smart card interface and a card. It sends and receives in turns, never both at once. Bit time is one elementary time unit (etu), a whole number of system clocks supplied as a configuration value. When the line runs at the default factors F=372 and D=1, one etu is 372 clocks of the card clock. A D below 1 is supplied as the larger precomputed count.

Each character is a low start bit, eight data bits and an even parity bit. The block also runs the character-level error exchange. When it receives a bad character, it pulls the line low near the end of that character. When it transmits, it watches for that low pulse and sends the character again, up to a fixed number of retries. After the last retry fails it drops the byte and pulses a failure flag.

The line can use direct or inverse coding, and there is a programmable extra guard time N between transmitted characters. The host side is a byte input with valid/ready and a byte output with a one-cycle valid and a separate parity-error pulse.

Top module: `sc_char_xcvr`

## Requirements
- R1: Every bit lasts exactly `cfg_etu` clocks (E). The receiver samples bit j on the clock edge 3 + j*E + floor(E/2) after the last clock at which `io_in` was still high before the start bit. `cfg_etu` is at least 4.
- R2: A transmitted character drives `io_drive_low` high for the start bit in the first cycle after the handshake. The eight data bits and the parity bit follow, each lasting E clocks. The parity bit makes the count of ones over data plus parity even. From 10 etu onward the line is released (`io_drive_low`=0).
- R3: With `cfg_inverse`=0, a high line means 1 and data goes least significant bit first. With `cfg_inverse`=1, a low line means 1 and data goes most significant bit first. Parity is computed on the logical values. Both directions follow this coding.
- R4: Let G = 12+`cfg_guard` etu, or G = 11 etu when `cfg_guard`=255. After an accepted character, `tx_ready` rises G*E clocks after that character's start. A byte that is already waiting starts one clock later.
- R5: The transmitter samples the line 11 etu after its start edge. If the line is low, it resends the same byte max(13,G) etu after the previous start.
- R6: After 3 retries are rejected (4 attempts in total), the byte is dropped. `tx_fail` pulses for one cycle max(13,G) etu after the last start, and the block returns to idle.
- R7: A correctly received character presents its byte on `rx_data` with `rx_valid` high for one cycle. This happens 3 + 9*E + floor(E/2) clocks after the last high sample before the start edge.
- R8: A received character with wrong parity gives a one-cycle `rx_perr` and no `rx_valid`. The block then holds `io_drive_low` high for exactly E clocks, starting 3 + 10*E + floor(E/2) clocks after the last high sample before the start edge.
- R9: If the line is high again at the middle of the start bit, the edge is treated as noise. No output is produced and the receiver returns to idle.
- R10: `tx_ready` is low while a character is being sent or received, and also in the cycle in which a falling edge is seen. The receiver ignores the block's own transmissions.
- R11: During reset `tx_ready` is 1. `io_drive_low`, `rx_valid`, `rx_perr` and `tx_fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_etu | input | ETU_W | Clocks per etu |
| cfg_guard | input | 8 | Extra guard time N in etu (255 selects 11-etu spacing) |
| cfg_inverse | input | 1 | 1 selects inverse coding |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte available |
| tx_ready | output | 1 | Byte accepted on this edge when valid |
| tx_fail | output | 1 | One-cycle pulse when a byte is dropped after the retries |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle pulse with a good byte |
| rx_perr | output | 1 | One-cycle pulse on a parity error |
| io_drive_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| io_in | input | 1 | Level of the shared line |

## Verification
The bench keeps the default parameters (a 16-bit etu count and three retries). It exercises etu lengths of 8, 7 and 10 clocks. The odd length makes the mid-bit sample sit off centre, and the longest reaches the latest point of the error window. Guard values 0, 3 and 255 cover the normal spacing, a stretched spacing, and the 11-etu case, where the acknowledge sample and the end of the character fall on the same edge. A card model on the wire rejects chosen attempts, so single retries and the full retry exhaustion are both reached under each coding.

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr #(
  parameter int ETU_W   = 16,
  parameter int RETRIES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] cfg_etu,
  input  logic [7:0]       cfg_guard,
  input  logic             cfg_inverse,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_fail,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             rx_perr,
  output logic             io_drive_low,
  input  logic             io_in
);

  localparam int EW = 9;
  localparam int RW = $clog2(RETRIES + 2);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX} st_t;

  st_t              st;
  logic [ETU_W-1:0] cnt;
  logic [EW-1:0]    ecnt;
  logic             io_m, io_s, io_p;
  logic [7:0]       txb, rxb;
  logic [RW-1:0]    tries;
  logic             nack, rpar, rerr;

  logic [ETU_W-1:0] half;
  logic             etu_end, mid, fall, nack_now, tx_done, tx_lvl, rbit;
  logic [EW-1:0]    ecnt_nxt, guard_etu, retry_etu;
  logic [2:0]       bidx;

  assign half      = cfg_etu >> 1;
  assign etu_end   = cnt == cfg_etu - ETU_W'(1);
  assign mid       = cnt == half - ETU_W'(1);
  assign fall      = io_p & ~io_s;
  assign rbit      = io_s ^ cfg_inverse;
  assign ecnt_nxt  = ecnt + EW'(1);
  assign guard_etu = (cfg_guard == 8'hFF) ? EW'(11) : EW'(12) + EW'(cfg_guard);
  assign retry_etu = (guard_etu < EW'(13)) ? EW'(13) : guard_etu;
  assign nack_now  = (ecnt == EW'(10)) ? ~io_s : nack;
  assign tx_done   = (st == S_TX) && etu_end &&
                     (ecnt_nxt == (nack_now ? retry_etu : guard_etu));
  assign tx_ready  = (st == S_IDLE) && !fall;
  assign bidx      = cfg_inverse ? 3'(4'd8 - ecnt[3:0]) : 3'(ecnt[3:0] - 4'd1);

  always_comb begin
    if (ecnt == EW'(0))       tx_lvl = 1'b0;
    else if (ecnt <= EW'(8))  tx_lvl = txb[bidx] ^ cfg_inverse;
    else if (ecnt == EW'(9))  tx_lvl = (^txb) ^ cfg_inverse;
    else                      tx_lvl = 1'b1;
  end

  assign io_drive_low =
      ((st == S_TX) && (ecnt < EW'(10)) && !tx_lvl) ||
      ((st == S_RX) && rerr &&
       (((ecnt == EW'(10)) && (cnt >= half)) || ((ecnt == EW'(11)) && (cnt < half))));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ecnt <= '0;
      io_m <= 1'b1;
      io_s <= 1'b1;
      io_p <= 1'b1;
      txb <= '0;
      rxb <= '0;
      tries <= '0;
      nack <= 1'b0;
      rpar <= 1'b0;
      rerr <= 1'b0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      rx_perr <= 1'b0;
      tx_fail <= 1'b0;
    end else begin
      io_m <= io_in;
      io_s <= io_m;
      io_p <= io_s;
      rx_valid <= 1'b0;
      rx_perr <= 1'b0;
      tx_fail <= 1'b0;
      if (st != S_IDLE) begin
        if (etu_end) begin
          cnt <= '0;
          ecnt <= ecnt_nxt;
        end else begin
          cnt <= cnt + ETU_W'(1);
        end
      end
      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          ecnt <= '0;
          if (fall) begin
            st <= S_RX;
            rerr <= 1'b0;
            rpar <= 1'b0;
          end else if (tx_valid) begin
            st <= S_TX;
            txb <= tx_data;
            tries <= '0;
            nack <= 1'b0;
          end
        end
        S_TX: begin
          if (etu_end && ecnt == EW'(10)) nack <= ~io_s;
          if (tx_done) begin
            if (nack_now && tries != RW'(RETRIES)) begin
              tries <= tries + RW'(1);
              cnt <= '0;
              ecnt <= '0;
              nack <= 1'b0;
            end else begin
              st <= S_IDLE;
              tx_fail <= nack_now;
            end
          end
        end
        S_RX: begin
          if (mid) begin
            if (ecnt == EW'(0)) begin
              if (io_s) st <= S_IDLE;
            end else if (ecnt <= EW'(8)) begin
              rxb <= cfg_inverse ? {rxb[6:0], rbit} : {rbit, rxb[7:1]};
              rpar <= rpar ^ rbit;
            end else if (ecnt == EW'(9)) begin
              if (rpar ^ rbit) begin
                rerr <= 1'b1;
                rx_perr <= 1'b1;
              end else begin
                rx_valid <= 1'b1;
                rx_data <= rxb;
              end
            end
          end
          if (!rerr && etu_end && ecnt == EW'(10)) st <= S_IDLE;
          if (rerr && mid && ecnt == EW'(11)) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_char_xcvr_chk.sv
module sc_char_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_fail,
  input logic rx_valid,
  input logic rx_perr,
  input logic io_drive_low
);

  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> io_drive_low);

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !io_drive_low);

  p_rx_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_rx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !io_drive_low);

  p_perr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_perr));

  p_perr_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |=> !io_drive_low);

  p_fail_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fail |=> !tx_fail);

endmodule

bind sc_char_xcvr sc_char_xcvr_chk u_chk (.*);

// File: tb/sc_char_xcvr_test.sv
module sc_char_xcvr_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] cfg_etu = 16'd8;
  logic [7:0]  cfg_guard = 8'd0;
  logic        cfg_inverse = 1'b0;
  logic [7:0]  tx_data = 8'd0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_fail, rx_valid, rx_perr, io_drive_low;
  logic [7:0]  rx_data;
  logic        card_low = 1'b0;
  logic        io_in;

  assign io_in = ~(io_drive_low | card_low);

  sc_char_xcvr uut (
    .clk(clk), .rst_n(rst_n), .cfg_etu(cfg_etu), .cfg_guard(cfg_guard),
    .cfg_inverse(cfg_inverse), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_fail(tx_fail), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .io_drive_low(io_drive_low),
    .io_in(io_in)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] txq_b[$];
  int         txq_n[$];
  bit         hs_pend = 0;

  bit m_act = 0;
  int m_a, m_att, m_nacks;
  logic [7:0] m_b;
  bit c_req = 0, c_act = 0, c_bad, c_glitch;
  int c_s;
  logic [7:0] c_b;
  logic [7:0] dec;
  int dec_count = 0, rx_cnt = 0, pe_cnt = 0, fail_cnt = 0;

  int E, h, G, L, rel, f, rend;
  bit e_drive, e_ready, e_fail, e_rv, e_pe, rx_busy, nk, lv;
  string dtag, rtag;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic bit lvl(logic [7:0] b, bit inv, bit bad, int j);
    bit v;
    if (j == 0) return 1'b0;
    if (j <= 8) v = inv ? b[8-j] : b[j-1];
    else if (j == 9) v = (^b) ^ bad;
    else return 1'b1;
    return v ^ inv;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      E = int'(cfg_etu); h = E / 2;
      G = (cfg_guard == 8'hFF) ? 11 : 12 + int'(cfg_guard);
      L = (G < 13) ? 13 : G;
      e_drive = 0; e_fail = 0; e_rv = 0; e_pe = 0; rx_busy = 0;
      dtag = "R2";
      if (c_req) begin c_act = 1; c_s = cyc; c_req = 0; end
      if (hs_pend) begin
        m_act = 1; m_a = cyc; m_att = 0;
        m_b = txq_b.pop_front(); m_nacks = txq_n.pop_front();
        hs_pend = 0;
      end
      tx_valid = (txq_b.size() > 0);
      if (tx_valid) tx_data = txq_b[0];
      if (m_act) begin
        nk = (m_att < m_nacks);
        if (cyc == m_a + (nk ? L : G) * E) begin
          if (nk && m_att < 3) begin m_att++; m_a = cyc; end
          else begin e_fail = nk; m_act = 0; end
        end
      end
      if (m_act) begin
        rel = cyc - m_a;
        if (rel < 10 * E) begin
          e_drive = !lvl(m_b, cfg_inverse, 0, rel / E);
          dtag = (m_att > 0) ? "R5" : (cfg_inverse ? "R3" : "R2");
        end
        if (rel % E == h && rel / E < 10) begin
          lv = io_in ^ cfg_inverse;
          if (rel / E >= 1 && rel / E <= 8) begin
            if (cfg_inverse) dec[8 - rel / E] = lv; else dec[rel / E - 1] = lv;
          end
          if (rel / E == 9) begin
            dec_count++;
            chk(dec == m_b && ((^dec) ^ lv) == 1'b0, cfg_inverse ? "R1 R3 decoded" : "R1 decoded",
                int'(dec), int'(m_b));
          end
        end
      end
      if (c_act) begin
        f = c_s + 3;
        rend = c_glitch ? f + h : (c_bad ? f + 11 * E + h : f + 11 * E);
        if (cyc >= rend) c_act = 0;
        else begin
          rx_busy = (cyc >= c_s + 2);
          if (!c_glitch && cyc == f + 9 * E + h) begin e_rv = !c_bad; e_pe = c_bad; end
          if (c_bad && cyc >= f + 10 * E + h && cyc < f + 11 * E + h) begin
            e_drive = 1; dtag = "R8";
          end
        end
      end
      e_ready = !m_act && !rx_busy;
      rtag = rx_busy ? "R10 ready" : "R4 ready";
      chk(io_drive_low === e_drive, dtag, int'(io_drive_low), int'(e_drive));
      chk(tx_ready === e_ready, rtag, int'(tx_ready), int'(e_ready));
      chk(tx_fail === e_fail, "R6 fail", int'(tx_fail), int'(e_fail));
      chk(rx_valid === e_rv, c_glitch ? "R9 valid" : "R7 valid", int'(rx_valid), int'(e_rv));
      chk(rx_perr === e_pe, "R8 perr", int'(rx_perr), int'(e_pe));
      if (e_rv) chk(rx_data === c_b, cfg_inverse ? "R3 rx data" : "R7 rx data", int'(rx_data), int'(c_b));
      if (rx_valid) rx_cnt++;
      if (rx_perr) pe_cnt++;
      if (tx_fail) fail_cnt++;
      hs_pend = tx_valid && e_ready;
      card_low = 0;
      if (m_act && m_att < m_nacks && cyc >= m_a + 10 * E + h && cyc < m_a + 12 * E) card_low = 1;
      if (c_act) begin
        rel = cyc - c_s;
        if (c_glitch) card_low = (rel < 2);
        else if (rel < 10 * E) card_low = !lvl(c_b, cfg_inverse, c_bad, rel / E);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (m_act || hs_pend || txq_b.size() > 0 || c_act || c_req);
    repeat (3) @(posedge clk);
  endtask

  task automatic setup(int etu, int guard, bit inv);
    wait_idle();
    #1;
    cfg_etu = 16'(etu); cfg_guard = 8'(guard); cfg_inverse = inv;
  endtask

  task automatic send(logic [7:0] b, int n);
    @(posedge clk); #1;
    txq_b.push_back(b); txq_n.push_back(n);
  endtask

  task automatic card_send(logic [7:0] b, bit bad, bit gl);
    wait_idle();
    #1;
    c_b = b; c_bad = bad; c_glitch = gl; c_req = 1;
    wait_idle();
  endtask

  initial begin
    int d0, r0, p0, f0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(tx_ready === 1'b1 && io_drive_low === 1'b0 && rx_valid === 1'b0 &&
        rx_perr === 1'b0 && tx_fail === 1'b0, "R11 reset",
        {tx_ready, io_drive_low, rx_valid, rx_perr, tx_fail}, 5'b10000);
    rst_n = 1'b1;

    // R1 R2 R4: back-to-back bytes, guard 0
    setup(8, 0, 0);
    send(8'hA5, 0); send(8'h3C, 0);
    // R4 stretched and short guard
    setup(8, 3, 0);
    send(8'h0F, 0); send(8'hF0, 0);
    setup(8, 255, 0);
    send(8'h81, 0); send(8'h7E, 0);
    // R3 inverse transmit
    setup(8, 0, 1);
    send(8'h96, 0); send(8'h3B, 0);
    // R5 single retry
    setup(8, 0, 0);
    d0 = dec_count;
    send(8'hC3, 1);
    wait_idle();
    chk(dec_count - d0 == 2, "R5 attempts", dec_count - d0, 2);
    // R6 retries exhausted then next byte
    f0 = fail_cnt; d0 = dec_count;
    send(8'h55, 4); send(8'h12, 0);
    wait_idle();
    chk(fail_cnt - f0 == 1, "R6 fail count", fail_cnt - f0, 1);
    chk(dec_count - d0 == 5, "R6 attempts", dec_count - d0, 5);
    // R7 receive, direct and inverse
    r0 = rx_cnt;
    card_send(8'h5A, 0, 0);
    setup(8, 0, 1);
    card_send(8'h3F, 0, 0);
    chk(rx_cnt - r0 == 2, "R7 rx count", rx_cnt - r0, 2);
    // R8 parity error
    setup(8, 0, 0);
    p0 = pe_cnt;
    card_send(8'h99, 1, 0);
    chk(pe_cnt - p0 == 1, "R8 perr count", pe_cnt - p0, 1);
    // R9 glitch rejected
    r0 = rx_cnt; p0 = pe_cnt;
    card_send(8'h00, 0, 1);
    chk(rx_cnt == r0 && pe_cnt == p0, "R9 glitch", rx_cnt - r0 + pe_cnt - p0, 0);
    // R10 own transmission not received
    r0 = rx_cnt;
    send(8'hE7, 0);
    wait_idle();
    chk(rx_cnt == r0, "R10 own tx ignored", rx_cnt - r0, 0);
    // odd etu length
    setup(7, 0, 0);
    send(8'h2D, 1);
    card_send(8'hE1, 0, 0);
    card_send(8'h44, 1, 0);
    setup(7, 2, 1);
    send(8'h6B, 2);
    card_send(8'hC8, 1, 0);
    // long etu with 11-etu spacing and a retry
    setup(10, 255, 0);
    send(8'hB4, 1); send(8'h09, 0);
    setup(10, 255, 1);
    send(8'h77, 4);
    card_send(8'h1E, 0, 0);
    wait_idle();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=finished", cyc);
    finish_run();
  end

endmodule